// File: doc/BRIEF.md
# Two-Way Byte-Parity Transceiver Stage

This block carries a 16-bit word between an A side and a B side, in both directions at once. Each direction passes its word, plus one parity bit per byte, through its own storage stage. The stage can follow its input directly, hold the word it last took, or load a new word on a capture strobe sampled at the rising edge of the system clock. Each direction is steered only by its own latch enable, capture strobe and output enable. The two directions share just one control: the odd/even parity sense.

From A to B the block either computes fresh parity for the outgoing bytes or passes the arriving parity bits through and checks them. From B to A it always passes the parity through and checks it. Each direction checks the word it is presenting, not the raw input. It reports a mismatch in either byte on one active-low flag. Beside the flag is a drive-enable, so several flags can be combined as a wired-AND. Clearing a direction's output enable masks its flag while data settles.

Tri-state ports appear as separate value and enable signals. The reset is asynchronous and active-low, and its release is synchronised to the clock.

Top module: `duplex_parity_xcvr`

## Requirements
- R1: With a direction's latch enable high, its destination data and parity outputs follow that direction's source inputs in the same cycle, with no clock edge needed.
- R2: With the latch enable low, a capture strobe high at a rising clock edge loads the source word and parity into that direction's stage, and the stage presents it from then on.
- R3: With the latch enable low and no capture strobe, the presented word stays unchanged while the source inputs change.
- R4: Each direction's stage and outputs are unaffected by the other direction's latch enable, capture strobe, output enable and data.
- R5: With gen_sel=1, pb_out[0] is computed over b_out[7:0] and pb_out[1] over b_out[15:8]. With odd_sel=1 each 9-bit group (byte plus its parity bit) holds an odd count of ones; with odd_sel=0 the count is even.
- R6: With gen_sel=0, pb_out carries the stored A-side parity bits unchanged. err_ab_n is 0 while oe_ab=1 and either presented byte fails the selected parity sense.
- R7: The B-to-A direction always passes pb_in through to pa_out and checks it, whatever gen_sel is. err_ba_n is 0 while oe_ba=1 and either presented byte fails. Bit 0 of each parity field covers data bits 7:0, and bit 1 covers bits 15:8.
- R8: A change of odd_sel changes the parity sense of both directions at once, in both generation and checking.
- R9: A direction's error flag is inactive (1) whenever its output enable is 0. The A-to-B flag is also never active in generate mode.
- R10: b_oe equals oe_ab and a_oe equals oe_ba.
- R11: While reset is active, both stages present data zero, parity bits equal to odd_sel (valid for either sense), and inactive flags. Until the next load, the parity stays valid when odd_sel changes.
- R12: Each flag's drive-enable is 1 exactly when the matching active-low flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| odd_sel | input | 1 | Parity sense for both directions, 1 = odd |
| gen_sel | input | 1 | A-to-B parity mode, 1 = generate, 0 = check |
| le_ab | input | 1 | A-to-B latch enable, 1 = transparent |
| cap_ab | input | 1 | A-to-B capture strobe |
| oe_ab | input | 1 | A-to-B output enable |
| a_in | input | 16 | A-side data in |
| pa_in | input | 2 | A-side parity in, bit i covers byte i |
| b_out | output | 16 | B-side data out |
| pb_out | output | 2 | B-side parity out |
| b_oe | output | 1 | B-side drive enable |
| err_ab_n | output | 1 | A-to-B parity error, active low |
| err_ab_drv | output | 1 | Drive-enable for err_ab_n |
| le_ba | input | 1 | B-to-A latch enable, 1 = transparent |
| cap_ba | input | 1 | B-to-A capture strobe |
| oe_ba | input | 1 | B-to-A output enable |
| b_in | input | 16 | B-side data in |
| pb_in | input | 2 | B-side parity in, bit i covers byte i |
| a_out | output | 16 | A-side data out |
| pa_out | output | 2 | A-side parity out |
| a_oe | output | 1 | A-side drive enable |
| err_ba_n | output | 1 | B-to-A parity error, active low |
| err_ba_drv | output | 1 | Drive-enable for err_ba_n |

## Verification
The bench corrupts the high and the low byte separately. A checker that looked at only one byte, or swapped the byte-to-bit order, would miss one of these cases. It flips odd_sel while data is held, which exposes a design that latched the sense or applied it to one direction only. It holds words against changing inputs, which exposes a stage that leaks input while neither loading nor transparent. It also checks that parity is valid straight out of reset in both senses, and that the flags stay quiet with the output enable off and in generate mode even when the A-side parity is garbage. A design that zeroed the parity at reset, or let the flag through regardless of the enable, would fail these checks.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_PASS = 2'd2
  } stage_op_e;

  function automatic stage_op_e stage_op(input logic le, input logic cap);
    if (le)       return OP_PASS;
    else if (cap) return OP_LOAD;
    else          return OP_HOLD;
  endfunction

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/xcvr_stage.sv
module xcvr_stage
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic         cap,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         fresh
);
  stage_op_e     op;
  logic [W-1:0]  held_q, held_d;
  logic          fresh_q, fresh_d;
  logic          load_en;

  always_comb begin
    op      = stage_op(le, cap);
    load_en = (op != OP_HOLD);
    held_d  = load_en ? din : held_q;
    fresh_d = fresh_q & ~load_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= '0;
      fresh_q <= 1'b1;
    end else begin
      held_q  <= held_d;
      fresh_q <= fresh_d;
    end
  end

  always_comb begin
    dout  = (op == OP_PASS) ? din : held_q;
    fresh = (op != OP_PASS) & fresh_q;
  end
endmodule

// File: rtl/xcvr_parity.sv
module xcvr_parity #(
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8
) (
  input  logic [NBYTES*BYTE_W-1:0] dat,
  input  logic [NBYTES-1:0]        par_in,
  input  logic                     odd,
  output logic [NBYTES-1:0]        par_gen,
  output logic [NBYTES-1:0]        bad
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic x;
    assign x          = ^dat[i*BYTE_W +: BYTE_W];
    assign par_gen[i] = x ^ odd;
    assign bad[i]     = x ^ par_in[i] ^ odd;
  end
endmodule

// File: rtl/duplex_parity_xcvr.sv
module duplex_parity_xcvr #(
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     odd_sel,
  input  logic                     gen_sel,
  input  logic                     le_ab,
  input  logic                     cap_ab,
  input  logic                     oe_ab,
  input  logic [NBYTES*BYTE_W-1:0] a_in,
  input  logic [NBYTES-1:0]        pa_in,
  output logic [NBYTES*BYTE_W-1:0] b_out,
  output logic [NBYTES-1:0]        pb_out,
  output logic                     b_oe,
  output logic                     err_ab_n,
  output logic                     err_ab_drv,
  input  logic                     le_ba,
  input  logic                     cap_ba,
  input  logic                     oe_ba,
  input  logic [NBYTES*BYTE_W-1:0] b_in,
  input  logic [NBYTES-1:0]        pb_in,
  output logic [NBYTES*BYTE_W-1:0] a_out,
  output logic [NBYTES-1:0]        pa_out,
  output logic                     a_oe,
  output logic                     err_ba_n,
  output logic                     err_ba_drv
);
  localparam int DW = NBYTES * BYTE_W;
  localparam int SW = DW + NBYTES;

  logic          rst_sync_n;

  logic [SW-1:0] q_ab, q_ba;
  logic          fresh_ab, fresh_ba;
  logic [NBYTES-1:0] gen_ab, gen_ba, bad_ab, bad_ba;
  logic [NBYTES-1:0] pres_ab, pres_ba;
  logic          err_ab, err_ba;

  xcvr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // A to B
  xcvr_stage #(.W(SW)) u_stage_ab (
    .clk(clk), .rst_n(rst_sync_n), .le(le_ab), .cap(cap_ab),
    .din({pa_in, a_in}), .dout(q_ab), .fresh(fresh_ab)
  );

  always_comb begin
    pres_ab = (gen_sel | fresh_ab) ? gen_ab : q_ab[SW-1:DW];
  end

  xcvr_parity #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_par_ab (
    .dat(q_ab[DW-1:0]), .par_in(pres_ab), .odd(odd_sel),
    .par_gen(gen_ab), .bad(bad_ab)
  );

  // B to A: always check
  xcvr_stage #(.W(SW)) u_stage_ba (
    .clk(clk), .rst_n(rst_sync_n), .le(le_ba), .cap(cap_ba),
    .din({pb_in, b_in}), .dout(q_ba), .fresh(fresh_ba)
  );

  always_comb begin
    pres_ba = fresh_ba ? gen_ba : q_ba[SW-1:DW];
  end

  xcvr_parity #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_par_ba (
    .dat(q_ba[DW-1:0]), .par_in(pres_ba), .odd(odd_sel),
    .par_gen(gen_ba), .bad(bad_ba)
  );

  always_comb begin
    err_ab     = oe_ab & (|bad_ab);
    err_ba     = oe_ba & (|bad_ba);
    b_out      = q_ab[DW-1:0];
    pb_out     = pres_ab;
    b_oe       = oe_ab;
    err_ab_n   = ~err_ab;
    err_ab_drv = err_ab;
    a_out      = q_ba[DW-1:0];
    pa_out     = pres_ba;
    a_oe       = oe_ba;
    err_ba_n   = ~err_ba;
    err_ba_drv = err_ba;
  end
endmodule

// File: rtl/duplex_parity_xcvr_chk.sv
module duplex_parity_xcvr_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gen_sel,
  input logic          le_ab,
  input logic          cap_ab,
  input logic          oe_ab,
  input logic [DW-1:0] a_in,
  input logic [DW-1:0] b_out,
  input logic          b_oe,
  input logic          err_ab_n,
  input logic          err_ab_drv,
  input logic          oe_ba,
  input logic          a_oe,
  input logic          err_ba_n,
  input logic          err_ba_drv
);
  // R1: transparent stage follows the source
  a_r1_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    le_ab |-> (b_out == a_in));

  // R3: hold keeps the presented word
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && !cap_ab) ##1 !le_ab |-> $stable(b_out));

  // R9: masked flags stay quiet
  a_r9_mask_ab: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_ab |-> err_ab_n);
  a_r9_mask_ba: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_ba |-> err_ba_n);
  a_r9_gen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    gen_sel |-> err_ab_n);

  // R10: port enables follow the output enables
  a_r10_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe == oe_ab) && (a_oe == oe_ba));

  // R12: drive-enable is the complement of the flag
  a_r12_drv: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ab_drv != err_ab_n) && (err_ba_drv != err_ba_n));
endmodule

bind duplex_parity_xcvr duplex_parity_xcvr_chk #(.DW(NBYTES*BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_sel(gen_sel), .le_ab(le_ab),
  .cap_ab(cap_ab), .oe_ab(oe_ab), .a_in(a_in), .b_out(b_out),
  .b_oe(b_oe), .err_ab_n(err_ab_n), .err_ab_drv(err_ab_drv),
  .oe_ba(oe_ba), .a_oe(a_oe), .err_ba_n(err_ba_n), .err_ba_drv(err_ba_drv)
);

// File: tb/duplex_parity_xcvr_bench.sv
module duplex_parity_xcvr_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, odd_sel, gen_sel;
  logic le_ab, cap_ab, oe_ab, le_ba, cap_ba, oe_ba;
  logic [15:0] a_in, b_in, b_out, a_out;
  logic [1:0]  pa_in, pb_in, pb_out, pa_out;
  logic b_oe, a_oe, err_ab_n, err_ab_drv, err_ba_n, err_ba_drv;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  duplex_parity_xcvr u_duplex_parity_xcvr (
    .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .gen_sel(gen_sel),
    .le_ab(le_ab), .cap_ab(cap_ab), .oe_ab(oe_ab), .a_in(a_in), .pa_in(pa_in),
    .b_out(b_out), .pb_out(pb_out), .b_oe(b_oe), .err_ab_n(err_ab_n),
    .err_ab_drv(err_ab_drv), .le_ba(le_ba), .cap_ba(cap_ba), .oe_ba(oe_ba),
    .b_in(b_in), .pb_in(pb_in), .a_out(a_out), .pa_out(pa_out), .a_oe(a_oe),
    .err_ba_n(err_ba_n), .err_ba_drv(err_ba_drv)
  );

  // parity bit i over byte i, making the 9-bit count odd when odd=1
  function automatic logic [1:0] want_par(input logic [15:0] d, input logic odd);
    return {^d[15:8] ^ odd, ^d[7:0] ^ odd};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 0; odd_sel = 1; gen_sel = 0;
    le_ab = 0; cap_ab = 0; oe_ab = 1; le_ba = 0; cap_ba = 0; oe_ba = 1;
    a_in = 16'hFFFF; b_in = 16'hFFFF; pa_in = 0; pb_in = 0;
    repeat (3) tick();
    check("R11 b_out zero", b_out, 0);
    check("R11 a_out zero", a_out, 0);
    check("R11 pb odd", pb_out, 2'b11);
    check("R11 pa odd", pa_out, 2'b11);
    check("R11 flags", {err_ab_n, err_ba_n}, 2'b11);
    odd_sel = 0; #1;
    check("R11 pb even", pb_out, 2'b00);
    check("R11 pa even", pa_out, 2'b00);
    @(negedge clk); rst_n = 1;
    repeat (4) tick();
    check("R11 after release", {a_out, b_out}, 0);
    check("R11 flags after release", {err_ab_n, err_ba_n}, 2'b11);
  endtask

  task automatic t_transparent();
    odd_sel = 1; gen_sel = 0;
    le_ab = 1; a_in = 16'hA55A; pa_in = want_par(16'hA55A, 1);
    le_ba = 1; b_in = 16'h1234; pb_in = 2'b01;
    #1;
    check("R1 b follows", b_out, 16'hA55A);
    check("R1 pb follows", pb_out, want_par(16'hA55A, 1));
    check("R1 a follows", a_out, 16'h1234);
    check("R1 pa follows", pa_out, 2'b01);
    a_in = 16'h00C3; #1;
    check("R1 b follows no edge", b_out, 16'h00C3);
    tick();
  endtask

  task automatic t_capture_hold();
    le_ab = 0; le_ba = 0;
    a_in = 16'h5A01; pa_in = 2'b10; cap_ab = 1;
    tick(); cap_ab = 0;
    check("R2 captured", b_out, 16'h5A01);
    check("R2 captured parity", pb_out, 2'b10);
    a_in = 16'hFFFF; pa_in = 2'b01;
    repeat (2) tick();
    check("R3 hold data", b_out, 16'h5A01);
    check("R3 hold parity", pb_out, 2'b10);
  endtask

  task automatic t_independent();
    le_ba = 0; b_in = 16'h7E81; pb_in = 2'b11; cap_ba = 1;
    tick(); cap_ba = 0;
    check("R2 ba captured", a_out, 16'h7E81);
    a_in = 16'h0F0F; cap_ab = 1; le_ab = 0; oe_ab = 0;
    tick(); cap_ab = 0;
    check("R4 a_out untouched", a_out, 16'h7E81);
    check("R4 pa_out untouched", pa_out, 2'b11);
    check("R10 a_oe", a_oe, 1'b1);
    check("R10 b_oe", b_oe, 1'b0);
    le_ab = 1; #1;
    check("R4 a_out with le_ab", a_out, 16'h7E81);
    oe_ab = 1;
    tick();
  endtask

  task automatic t_generate();
    gen_sel = 1; odd_sel = 1; le_ab = 1; a_in = 16'h0301; pa_in = 2'b01;
    #1;
    check("R5 gen odd", pb_out, 2'b10);
    check("R9 gen no flag", err_ab_n, 1'b1);
    odd_sel = 0; #1;
    check("R5 gen even", pb_out, 2'b01);
    check("R8 gen sense", pb_out, want_par(16'h0301, 0));
    tick();
  endtask

  task automatic t_check_ab();
    gen_sel = 0; odd_sel = 1; le_ab = 1; a_in = 16'h0301; pa_in = 2'b10;
    #1;
    check("R6 pass-through", pb_out, 2'b10);
    check("R6 valid flag", {err_ab_n, err_ab_drv}, 2'b10);
    pa_in = 2'b11; #1;
    check("R6 low byte bad", err_ab_n, 1'b0);
    check("R12 ab drv", err_ab_drv, 1'b1);
    pa_in = 2'b00; #1;
    check("R6 high byte bad", err_ab_n, 1'b0);
    tick();
    le_ab = 0; cap_ab = 1; pa_in = 2'b11;
    tick(); cap_ab = 0; pa_in = 2'b10;
    repeat (2) tick();
    check("R6 stored bad word flags", err_ab_n, 1'b0);
    check("R6 stored parity", pb_out, 2'b11);
  endtask

  task automatic t_check_ba();
    gen_sel = 1; odd_sel = 0; le_ba = 1; b_in = 16'h0F01; pb_in = 2'b01;
    #1;
    check("R7 pass-through", pa_out, 2'b01);
    check("R7 valid", err_ba_n, 1'b1);
    pb_in = 2'b11; #1;
    check("R7 high byte bad", {err_ba_n, err_ba_drv}, 2'b01);
    pb_in = 2'b00; #1;
    check("R7 low byte bad", err_ba_n, 1'b0);
    tick();
  endtask

  task automatic t_odd_even();
    gen_sel = 0; odd_sel = 0; le_ab = 1; le_ba = 1;
    a_in = 16'h0F01; pa_in = 2'b01; b_in = 16'h0F01; pb_in = 2'b01;
    #1;
    check("R8 even both ok", {err_ab_n, err_ba_n}, 2'b11);
    odd_sel = 1; #1;
    check("R8 odd both bad", {err_ab_n, err_ba_n}, 2'b00);
    tick();
  endtask

  task automatic t_masking();
    oe_ab = 0; oe_ba = 0; #1;
    check("R9 ab masked", {err_ab_n, err_ab_drv}, 2'b10);
    check("R9 ba masked", {err_ba_n, err_ba_drv}, 2'b10);
    check("R10 enables low", {b_oe, a_oe}, 2'b00);
    oe_ab = 1; oe_ba = 1; #1;
    check("R9 unmasked", {err_ab_n, err_ba_n}, 2'b00);
    tick();
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_capture_hold();
    t_independent();
    t_generate();
    t_check_ab();
    t_check_ba();
    t_odd_even();
    t_masking();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule